// File: doc/BRIEF.md
# Stream Packet Framer with One-Beat Skid Slot

This block sits between a core that produces 32-bit data beats and a stream master port that feeds a DMA engine. Beats enter through a valid/ready handshake and leave through a second valid/ready handshake. The output side also carries a last-beat flag and a byte-enable mask. The upstream core supplies no packet boundaries, so the block cuts the stream into packets itself. Software sets the packet length, in beats, through a small register write port. A second register sets how many bytes of the closing beat are meaningful.

The upstream ready is registered, so the producer sees a stall one cycle after the downstream side applies it. A one-beat skid slot behind the output register catches the beat that arrives during that cycle. As a result no beat is lost or repeated, and the data rate stays at one beat per clock while nothing stalls. Configuration written during a packet is held back until that packet is complete.

Top module: `strm_framer`

## Requirements
- R1: A synchronous active-high reset clears both storage slots and the beat counter. After reset, `m_valid` is 0 and `s_ready` is 1. The reset values are: packet length 1 beat, so every beat is a last beat, and final-beat byte count 4, so the mask is 4'b1111.
- R2: Every beat accepted on the input (`s_valid` and `s_ready` both high) appears exactly once on the output, unchanged and in arrival order. It becomes visible no earlier than the cycle after it was accepted.
- R3: `s_ready` is driven from a register. It is low exactly while two beats are stored. The beat offered in the cycle when the downstream side first stalls is still taken and parked in the skid slot.
- R4: While `m_valid` is high and `m_ready` is low, `m_data`, `m_last` and `m_keep` hold their values into the next cycle.
- R5: A write with `cfg_sel`=0 sets the packet length N. `m_last` is high on output beats N, 2N, 3N, … counted over the output handshakes since the last boundary, and low on all other valid beats.
- R6: A length write of 0 is stored as 1.
- R7: Length and byte-count writes made while a packet is in progress do not affect that packet. They apply from the next packet on.
- R8: On every valid beat that is not a last beat, `m_keep` is 4'b1111.
- R9: A write with `cfg_sel`=1 sets the byte count B. On a last beat, `m_keep` has its low B bits set and the other bits clear. B=0 or B>4 is stored as 4.
- R10: With `s_valid` and `m_ready` both held high, one beat completes on the output in every cycle once the pipeline has filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Selects the register: 0 = packet length in beats, 1 = final-beat byte count |
| cfg_wdata | input | LEN_W (16) | Configuration write value |
| s_data | input | DATA_W (32) | Upstream beat data |
| s_valid | input | 1 | Upstream beat present |
| s_ready | output | 1 | Registered upstream acceptance |
| m_data | output | DATA_W (32) | Downstream beat data |
| m_valid | output | 1 | Downstream beat present |
| m_ready | input | 1 | Downstream acceptance |
| m_last | output | 1 | Last beat of a packet |
| m_keep | output | DATA_W/8 (4) | Byte enables, meaningful on the last beat |

## Verification
The bench builds the block with its defaults: a 32-bit data path, a 4-bit byte mask and a 16-bit length field. The 4-bit mask makes every final-beat byte count reachable, including the clamp of out-of-range counts to the full mask. Short packet lengths from 1 to 8 beats produce many packet boundaries, so configuration writes land at the start of packets and in their middle. Random and patterned stalls on both sides fill the skid slot repeatedly, including stalls that begin while a last beat is waiting on the output.

// File: rtl/strm_framer_pkg.sv
package strm_framer_pkg;

   // Register selected by the configuration write port
   typedef enum logic {
      CFG_LEN   = 1'b0,
      CFG_BYTES = 1'b1
   } cfg_sel_e;

endpackage

// File: rtl/strm_skid.sv
// Output register with one skid slot behind it. The upstream ready is a
// register: it drops only once the skid slot holds a beat.
module strm_skid #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] in_data,
   input  logic         in_valid,
   output logic         in_ready,
   output logic [W-1:0] out_data,
   output logic         out_valid,
   input  logic         out_ready
);

   logic         slot_full;
   logic [W-1:0] slot_data;
   logic         head_full;
   logic [W-1:0] head_data;
   logic         take;
   logic         head_free;

   assign in_ready  = ~slot_full;
   assign take      = in_valid & ~slot_full;
   assign head_free = ~head_full | out_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         head_full <= 1'b0;
         slot_full <= 1'b0;
      end else if (head_free) begin
         if (slot_full) begin
            head_full <= 1'b1;
            slot_full <= 1'b0;
         end else begin
            head_full <= take;
         end
      end else if (take) begin
         slot_full <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (head_free) begin
         head_data <= slot_full ? slot_data : in_data;
      end
      if (!head_free && take) begin
         slot_data <= in_data;
      end
   end

   assign out_data  = head_data;
   assign out_valid = head_full;

endmodule

// File: rtl/strm_frame_ctl.sv
// Configuration registers, per-packet snapshot, beat counter and last/keep.
module strm_frame_ctl
   import strm_framer_pkg::*;
#(
   parameter int LEN_W  = 16,
   parameter int KEEP_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  cfg_sel_e          cfg_sel,
   input  logic [LEN_W-1:0]  cfg_wdata,
   input  logic              beat_valid,
   input  logic              beat_ready,
   output logic              beat_last,
   output logic [KEEP_W-1:0] beat_keep
);

   localparam int BC_W = $clog2(KEEP_W + 1);
   localparam logic [LEN_W-1:0] KEEP_MAX_L = LEN_W'(KEEP_W);
   localparam logic [BC_W-1:0]  KEEP_MAX_B = BC_W'(KEEP_W);

   logic [LEN_W-1:0]  len_prog, len_act, beat_cnt;
   logic [BC_W-1:0]   byt_prog, byt_act;
   logic              at_end, fire, snap;
   logic [KEEP_W-1:0] tail_mask;

   // Software-visible registers, with the 0 and out-of-range substitutions
   always_ff @(posedge clk) begin
      if (rst) begin
         len_prog <= LEN_W'(1);
         byt_prog <= KEEP_MAX_B;
      end else if (cfg_we) begin
         if (cfg_sel == CFG_LEN) begin
            len_prog <= (cfg_wdata == '0) ? LEN_W'(1) : cfg_wdata;
         end else begin
            byt_prog <= (cfg_wdata == '0 || cfg_wdata > KEEP_MAX_L)
                        ? KEEP_MAX_B : cfg_wdata[BC_W-1:0];
         end
      end
   end

   assign fire   = beat_valid & beat_ready;
   assign at_end = (beat_cnt == len_act - LEN_W'(1));
   // Take a new snapshot at a packet boundary or while idle before a first beat
   assign snap   = (fire & at_end) | ((beat_cnt == '0) & ~beat_valid);

   always_ff @(posedge clk) begin
      if (rst) begin
         len_act  <= LEN_W'(1);
         byt_act  <= KEEP_MAX_B;
         beat_cnt <= '0;
      end else begin
         if (snap) begin
            len_act <= len_prog;
            byt_act <= byt_prog;
         end
         if (fire) begin
            beat_cnt <= at_end ? '0 : beat_cnt + LEN_W'(1);
         end
      end
   end

   // Low-aligned mask of byt_act ones
   for (genvar i = 0; i < KEEP_W; i++) begin : g_mask
      assign tail_mask[i] = (BC_W'(i) < byt_act);
   end

   assign beat_last = beat_valid & at_end;
   assign beat_keep = beat_last ? tail_mask : '1;

endmodule

// File: rtl/strm_framer.sv
module strm_framer
   import strm_framer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cfg_we,
   input  logic                cfg_sel,
   input  logic [LEN_W-1:0]    cfg_wdata,
   input  logic [DATA_W-1:0]   s_data,
   input  logic                s_valid,
   output logic                s_ready,
   output logic [DATA_W-1:0]   m_data,
   output logic                m_valid,
   input  logic                m_ready,
   output logic                m_last,
   output logic [DATA_W/8-1:0] m_keep
);

   localparam int KEEP_W = DATA_W / 8;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("strm_framer: DATA_W must be a whole number of bytes");
   end
   if (KEEP_W < 1 || KEEP_W > 16) begin : g_bad_keep
      $error("strm_framer: byte mask must be 1 to 16 bits");
   end
   if (LEN_W < $clog2(KEEP_W + 1)) begin : g_bad_len
      $error("strm_framer: LEN_W too narrow to hold a byte count");
   end

   logic m_valid_i;

   strm_skid #(.W(DATA_W)) u_skid (
      .clk       (clk),
      .rst       (rst),
      .in_data   (s_data),
      .in_valid  (s_valid),
      .in_ready  (s_ready),
      .out_data  (m_data),
      .out_valid (m_valid_i),
      .out_ready (m_ready)
   );

   strm_frame_ctl #(.LEN_W(LEN_W), .KEEP_W(KEEP_W)) u_ctl (
      .clk        (clk),
      .rst        (rst),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel_e'(cfg_sel)),
      .cfg_wdata  (cfg_wdata),
      .beat_valid (m_valid_i),
      .beat_ready (m_ready),
      .beat_last  (m_last),
      .beat_keep  (m_keep)
   );

   assign m_valid = m_valid_i;

endmodule

// File: rtl/strm_framer_chk.sv
module strm_framer_chk #(
   parameter int DATA_W = 32,
   parameter int KEEP_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              s_ready,
   input logic [DATA_W-1:0] m_data,
   input logic              m_valid,
   input logic              m_ready,
   input logic              m_last,
   input logic [KEEP_W-1:0] m_keep
);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (!m_valid && s_ready));

   // R4
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last) && $stable(m_keep)));

   // R8
   keep_full_chk: assert property (@(posedge clk) disable iff (rst)
      (m_valid && !m_last) |-> (m_keep == '1));

   // R9
   keep_shape_chk: assert property (@(posedge clk) disable iff (rst)
      m_valid |-> (m_keep[0] && ((KEEP_W'(m_keep + 1'b1) & m_keep) == '0)));

   // R3
   skid_stays_chk: assert property (@(posedge clk) disable iff (rst)
      (!s_ready && !m_ready) |=> !s_ready);

   // R3
   ready_low_full_chk: assert property (@(posedge clk) disable iff (rst)
      !s_ready |-> m_valid);

endmodule

bind strm_framer strm_framer_chk #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .s_ready (s_ready),
   .m_data  (m_data),
   .m_valid (m_valid),
   .m_ready (m_ready),
   .m_last  (m_last),
   .m_keep  (m_keep)
);

// File: tb/strm_framer_tb.sv
module strm_framer_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [31:0] s_data = '0;
   logic        s_valid = 1'b0;
   logic        s_ready;
   logic [31:0] m_data;
   logic        m_valid;
   logic        m_ready = 1'b0;
   logic        m_last;
   logic [3:0]  m_keep;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   // reference model state
   logic [31:0] q[$];
   int len_prog_m = 1, len_act_m = 1, byt_prog_m = 4, byt_act_m = 4, cnt_m = 0;
   int prod_idx = 0;
   int dut_hs = 0;
   bit stalled_prev = 0;
   string tag_last = "R1";

   strm_framer u_dut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
      .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready),
      .m_last(m_last), .m_keep(m_keep)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         failures++;
         $display("FAIL watchdog expired act=%0d exp<=100000", cyc);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   function automatic logic [31:0] pat(input int k);
      return {k[15:0], ~k[15:0]} ^ 32'h5A3C_0000;
   endfunction

   // compare outputs against the model (called at a falling edge)
   task automatic compare();
      bit exp_last;
      logic [3:0] exp_keep;
      chk(s_ready == (q.size() < 2), "R3", "s_ready", s_ready, q.size() < 2);
      chk(m_valid == (q.size() > 0), "R2", "m_valid", m_valid, q.size() > 0);
      if (q.size() > 0 && m_valid) begin
         exp_last = (cnt_m == len_act_m - 1);
         exp_keep = exp_last ? 4'((1 << byt_act_m) - 1) : 4'hF;
         chk(m_data == q[0], stalled_prev ? "R4" : "R2", "m_data", m_data, q[0]);
         chk(m_last == exp_last, tag_last, "m_last", m_last, exp_last);
         chk(m_keep == exp_keep, exp_last ? "R9" : "R8", "m_keep", m_keep, exp_keep);
         if (m_ready) dut_hs++;
      end
   endtask

   // advance the model across the coming rising edge
   task automatic model_step();
      int sz = q.size();
      bit hs = (sz > 0) && m_ready;
      bit at_end = (cnt_m == len_act_m - 1);
      bit acc = s_valid && (sz < 2);
      stalled_prev = (sz > 0) && !m_ready;
      if (hs) begin
         void'(q.pop_front());
         if (at_end) begin
            cnt_m = 0;
            len_act_m = len_prog_m;
            byt_act_m = byt_prog_m;
         end else begin
            cnt_m++;
         end
      end else if (cnt_m == 0 && sz == 0) begin
         len_act_m = len_prog_m;
         byt_act_m = byt_prog_m;
      end
      if (acc) begin
         q.push_back(s_data);
         prod_idx++;
      end
      if (cfg_we) begin
         if (!cfg_sel) len_prog_m = (cfg_wdata == 0) ? 1 : int'(cfg_wdata);
         else byt_prog_m = (cfg_wdata == 0 || cfg_wdata > 4) ? 4 : int'(cfg_wdata);
      end
   endtask

   task automatic cycle(input bit pv, input bit mr, input bit we, input bit sel,
                        input logic [15:0] wd);
      @(negedge clk);
      compare();
      s_valid = pv;
      s_data = pat(prod_idx);
      m_ready = mr;
      cfg_we = we;
      cfg_sel = sel;
      cfg_wdata = wd;
      model_step();
   endtask

   task automatic run(input int n, input int pv_pct, input int mr_pct);
      for (int i = 0; i < n; i++)
         cycle($urandom_range(99, 0) < pv_pct, $urandom_range(99, 0) < mr_pct, 1'b0, 1'b0, '0);
   endtask

   task automatic cfg(input bit sel, input int wd);
      cycle(1'b0, 1'b1, 1'b1, sel, 16'(wd));
   endtask

   initial begin
      int hs0;
      void'($urandom(7));
      repeat (3) @(negedge clk);
      // R1: state after reset
      chk(m_valid == 1'b0, "R1", "m_valid after reset", m_valid, 0);
      chk(s_ready == 1'b1, "R1", "s_ready after reset", s_ready, 1);
      rst = 1'b0;

      // R1: default length 1 and full mask on every beat
      tag_last = "R1";
      for (int i = 0; i < 10; i++) cycle(1'b1, 1'b1, 1'b0, 1'b0, '0);
      run(12, 70, 60);

      // R5: length 4, final beat 3 bytes, random stalls both sides
      tag_last = "R5";
      cfg(1'b0, 4);
      cfg(1'b1, 3);
      run(80, 70, 70);

      // R3: upstream always offering, downstream stall pattern fills the skid slot
      for (int i = 0; i < 48; i++) cycle(1'b1, (i % 5 == 0) || (i % 7 == 3), 1'b0, 1'b0, '0);
      run(6, 0, 100);

      // R7: writes in the middle of a packet apply from the next packet
      tag_last = "R7";
      cfg(1'b0, 5);
      cycle(1'b1, 1'b1, 1'b0, 1'b0, '0);
      cycle(1'b1, 1'b1, 1'b0, 1'b0, '0);
      cycle(1'b1, 1'b1, 1'b1, 1'b0, 16'd2);
      cycle(1'b1, 1'b0, 1'b1, 1'b1, 16'd1);
      for (int i = 0; i < 20; i++) cycle(1'b1, (i % 3) != 1, 1'b0, 1'b0, '0);
      run(30, 60, 50);

      // R6: length 0 stored as 1, byte count 0 stored as 4
      tag_last = "R6";
      cfg(1'b0, 0);
      cfg(1'b1, 0);
      run(30, 80, 60);

      // R9: byte count 2, then out-of-range 7 clamps to 4
      tag_last = "R5";
      cfg(1'b0, 2);
      cfg(1'b1, 2);
      run(30, 80, 70);
      cfg(1'b1, 7);
      run(30, 80, 70);
      cfg(1'b1, 1);
      cfg(1'b0, 3);
      run(30, 90, 80);

      // R10: full rate once filled
      cfg(1'b0, 8);
      run(4, 0, 100);
      for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 1'b0, 1'b0, '0);
      hs0 = dut_hs;
      for (int i = 0; i < 32; i++) cycle(1'b1, 1'b1, 1'b0, 1'b0, '0);
      chk(dut_hs - hs0 == 32, "R10", "beats in 32 cycles", dut_hs - hs0, 32);

      // drain and confirm every accepted beat left
      run(6, 0, 100);
      chk(q.size() == 0 && !m_valid, "R2", "drained", m_valid, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule